// File: doc/BRIEF.md
# Programmable Burst Address Generator

This block produces the column address for every beat of a memory read or write burst. A start pulse loads a starting column and a read or write flag. From the next cycle the block presents one column per clock until the burst is complete, terminated or restarted. The mode fields select the length of the burst, the order in which columns are visited, and whether writes are cut to a single beat.

A clock enable suspends the block. While it is low, the address, the beat count and the valid and last flags do not change, and any start or terminate pulse is ignored. The mode fields are captured when the burst starts, so a burst runs to its end with the settings it began with. Aligning columns to CAS latency and decoding commands belong to other blocks.

Top module: `burst_addr_gen`

## Requirements
- R1: When start is sampled high on a rising edge with clk_en high, col_valid is high in the following cycle and col_out equals the loaded start column.
- R2: The length field mode_bl is decoded as 000 = 1 beat, 001 = 2 beats, 010 = 4 beats and 011 = 8 beats; 100, 101 and 110 give 1 beat. col_last is high exactly on the final beat, and col_valid falls in the cycle after it.
- R3: With mode_ilv = 0, beat k presents the start column with its low log2(length) bits replaced by (start + k) modulo the length. The address wraps inside the aligned block and the upper bits never change.
- R4: With mode_ilv = 1, beat k presents the start column with its low log2(length) bits replaced by (start XOR k).
- R5: mode_bl = 111 selects a full page: columns follow (start + k) modulo 512 whatever mode_ilv says, col_last stays low, and the burst continues until it is terminated or restarted.
- R6: With mode_wsingle = 1, a write burst (start_wr = 1) lasts one beat with col_last high. Read bursts keep the programmed length.
- R7: While clk_en is low, col_out, col_valid and col_last hold their values. Start and term pulses sampled in those cycles have no effect.
- R8: A term pulse sampled with clk_en high and start low ends the burst: col_valid and col_last are low in the next cycle.
- R9: A start pulse during a burst restarts it from the new column, and it takes priority over a simultaneous term pulse.
- R10: Changes to the mode inputs during a burst do not alter that burst's length or order.
- R11: After reset, and whenever col_valid is low, col_out is 0 and col_last is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; low freezes the block |
| start | input | 1 | Loads a new burst |
| start_col | input | COL_W (9) | Starting column |
| start_wr | input | 1 | 1 = write burst, 0 = read burst |
| term | input | 1 | Ends the current burst |
| mode_bl | input | 3 | Burst length code |
| mode_ilv | input | 1 | 0 = sequential order, 1 = interleaved order |
| mode_wsingle | input | 1 | 1 = write bursts last a single beat |
| col_out | output | COL_W (9) | Column of the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_last | output | 1 | The current beat is the final one |

## Verification
Every output comes from one register stage. Beat 0 is due in the first cycle after the edge that samples start, beat k is due k enabled edges later, and the drop of col_valid is due one edge after the last beat or the term pulse. The bench drives inputs on falling edges and reads outputs on the next falling edge, so each check lands one register stage after its stimulus. It sweeps all eight length codes, both orders, reads and writes, the single-write setting and start columns near block and page edges. Frozen cycles are counted so that the expected beat index stays in step with the design.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int COL_W_DEF = 9;

    typedef enum logic [2:0] {
        BL_ONE   = 3'b000,
        BL_TWO   = 3'b001,
        BL_FOUR  = 3'b010,
        BL_EIGHT = 3'b011,
        BL_PAGE  = 3'b111
    } bl_code_e;

endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec #(
    parameter int COL_W = burst_pkg::COL_W_DEF
) (
    input  logic [2:0]       bl_code,
    input  logic             is_wr,
    input  logic             wr_single,
    output logic [COL_W-1:0] len_mask,
    output logic             len_full
);
    import burst_pkg::*;

    logic [COL_W-1:0] mask_raw;
    logic             full_raw;

    always_comb begin
        mask_raw = '0;
        full_raw = 1'b0;
        case (bl_code_e'(bl_code))
            BL_TWO:   mask_raw = COL_W'(1);
            BL_FOUR:  mask_raw = COL_W'(3);
            BL_EIGHT: mask_raw = COL_W'(7);
            BL_PAGE: begin
                mask_raw = '1;
                full_raw = 1'b1;
            end
            default:  mask_raw = '0;
        endcase
    end

    // forcing single-beat writes overrides every length code
    always_comb begin
        if (is_wr && wr_single) begin
            len_mask = '0;
            len_full = 1'b0;
        end else begin
            len_mask = mask_raw;
            len_full = full_raw;
        end
    end

endmodule

// File: rtl/burst_col_order.sv
module burst_col_order #(
    parameter int COL_W = burst_pkg::COL_W_DEF
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_cnt,
    input  logic [COL_W-1:0] len_mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] ilv_xor;

    assign seq_sum = base_col + beat_cnt;
    assign ilv_xor = base_col ^ beat_cnt;

    for (genvar gi = 0; gi < COL_W; gi++) begin : g_bit
        always_comb begin
            if (!len_mask[gi]) begin
                col[gi] = base_col[gi];
            end else if (ilv) begin
                col[gi] = ilv_xor[gi];
            end else begin
                col[gi] = seq_sum[gi];
            end
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int COL_W = burst_pkg::COL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_wr,
    input  logic             term,
    input  logic [2:0]       mode_bl,
    input  logic             mode_ilv,
    input  logic             mode_wsingle,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             col_last
);
    typedef struct packed {
        logic             valid;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] mask;
    } burst_st_t;

    burst_st_t        st_d, st_q;
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic [COL_W-1:0] ord_col;
    logic             at_end;

    burst_len_dec #(.COL_W(COL_W)) u_len (
        .bl_code   (mode_bl),
        .is_wr     (start_wr),
        .wr_single (mode_wsingle),
        .len_mask  (dec_mask),
        .len_full  (dec_full)
    );

    burst_col_order #(.COL_W(COL_W)) u_order (
        .base_col (st_q.base),
        .beat_cnt (st_q.cnt),
        .len_mask (st_q.mask),
        .ilv      (st_q.ilv),
        .col      (ord_col)
    );

    assign at_end = st_q.valid && !st_q.full && (st_q.cnt == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            if (start) begin
                st_d.valid = 1'b1;
                st_d.full  = dec_full;
                st_d.ilv   = mode_ilv && !dec_full;
                st_d.base  = start_col;
                st_d.cnt   = '0;
                st_d.mask  = dec_mask;
            end else if (term) begin
                st_d.valid = 1'b0;
            end else if (st_q.valid) begin
                if (at_end) begin
                    st_d.valid = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + COL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_valid = st_q.valid;
    assign col_last  = at_end;
    assign col_out   = st_q.valid ? ord_col : '0;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int COL_W = burst_pkg::COL_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             start_wr,
    input logic             term,
    input logic             mode_wsingle,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             col_last
);
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && start |=> col_valid && (col_out == $past(start_col))); // R1

    AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && col_last && !start |=> !col_valid); // R2

    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && start && start_wr && mode_wsingle |=> col_last); // R6

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(col_out) && $stable(col_valid) && $stable(col_last)); // R7

    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && term && !start |=> !col_valid && !col_last); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> (col_out == '0) && !col_last); // R11

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_en       (clk_en),
    .start        (start),
    .start_col    (start_col),
    .start_wr     (start_wr),
    .term         (term),
    .mode_wsingle (mode_wsingle),
    .col_out      (col_out),
    .col_valid    (col_valid),
    .col_last     (col_last)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_en = 1'b1;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             start_wr = 1'b0;
    logic             term = 1'b0;
    logic [2:0]       mode_bl = 3'b000;
    logic             mode_ilv = 1'b0;
    logic             mode_wsingle = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             col_valid;
    logic             col_last;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen #(.COL_W(COL_W)) u_burst_addr_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en       (clk_en),
        .start        (start),
        .start_col    (start_col),
        .start_wr     (start_wr),
        .term         (term),
        .mode_bl      (mode_bl),
        .mode_ilv     (mode_ilv),
        .mode_wsingle (mode_wsingle),
        .col_out      (col_out),
        .col_valid    (col_valid),
        .col_last     (col_last)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int bl, input bit wr, input bit ws);
        if (wr && ws) return 1;
        case (bl)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 512;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int s, input int k, input int len, input bit ilv);
        int m;
        if (len == 512) return (s + k) % 512;
        m = len - 1;
        if (ilv) return (s & ~m & 511) | ((s ^ k) & m);
        return (s & ~m & 511) | ((s + k) & m);
    endfunction

    task automatic kick(input int s, input bit wr, input int bl, input bit ilv, input bit ws);
        @(negedge clk);
        start = 1'b1; start_col = COL_W'(s); start_wr = wr;
        mode_bl = 3'(bl); mode_ilv = ilv; mode_wsingle = ws;
        @(negedge clk);
        start = 1'b0;
    endtask

    // R2 R3 R4 R5 R6: one burst checked beat by beat
    task automatic run_burst(input int s, input bit wr, input int bl, input bit ilv, input bit ws);
        int len;
        int beats;
        len = exp_len(bl, wr, ws);
        beats = (len == 512) ? 515 : len;
        kick(s, wr, bl, ilv, ws);
        for (int k = 0; k < beats; k++) begin
            chk(len == 512 ? "R5 col" : (ilv ? "R4 col" : "R3 col"),
                col_out, exp_col(s, k, len, ilv));
            chk(wr && ws ? "R6 valid" : "R2 valid", col_valid, 1);
            chk(len == 512 ? "R5 last" : "R2 last", col_last,
                (len != 512 && k == len - 1) ? 1 : 0);
            @(negedge clk);
        end
        if (len == 512) begin
            term = 1'b1;
            @(negedge clk);
            term = 1'b0;
            chk("R5 end by term", col_valid, 0);
        end else begin
            chk("R2 end valid", col_valid, 0);
        end
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cols[7] = '{0, 5, 7, 13, 255, 510, 511};
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 valid", col_valid, 0);
        chk("R11 last", col_last, 0);
        chk("R11 col", col_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep of lengths, orders, directions and the single-write setting
        for (int bl = 0; bl < 8; bl++)
            for (int ilv = 0; ilv < 2; ilv++)
                for (int ci = 0; ci < 7; ci++)
                    for (int wr = 0; wr < 2; wr++)
                        for (int ws = 0; ws < 2; ws++)
                            run_burst(cols[ci], wr[0], bl, ilv[0], ws[0]);

        // R1: a new start loads its column into beat 0
        kick(300, 1'b0, 3, 1'b0, 1'b0);
        chk("R1 col", col_out, 300);
        chk("R1 valid", col_valid, 1);

        // R7: frozen cycles ignore start and term
        clk_en = 1'b0; start = 1'b1; start_col = 9'd99; term = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R7 col", col_out, 300);
            chk("R7 valid", col_valid, 1);
            chk("R7 last", col_last, 0);
        end
        clk_en = 1'b1; start = 1'b0; term = 1'b0;
        @(negedge clk);
        chk("R7 resume", col_out, 301);

        // R8: term ends the burst immediately
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk("R8 valid", col_valid, 0);
        chk("R8 last", col_last, 0);
        chk("R11 idle col", col_out, 0);

        // R9: restart beats a simultaneous term
        kick(40, 1'b0, 2, 1'b0, 1'b0);
        @(negedge clk);
        chk("R9 before", col_out, 41);
        start = 1'b1; start_col = 9'd100; term = 1'b1;
        @(negedge clk);
        start = 1'b0; term = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R9 col", col_out, 100 + k);
            chk("R9 last", col_last, k == 3 ? 1 : 0);
            @(negedge clk);
        end
        chk("R9 end", col_valid, 0);

        // R10: mode changes during a burst are ignored
        kick(3, 1'b0, 3, 1'b0, 1'b0);
        mode_bl = 3'b000; mode_ilv = 1'b1; mode_wsingle = 1'b1;
        for (int k = 0; k < 8; k++) begin
            chk("R10 col", col_out, (3 + k) % 8);
            chk("R10 last", col_last, k == 7 ? 1 : 0);
            @(negedge clk);
        end
        chk("R10 end", col_valid, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule